// File: doc/BRIEF.md
# Clear-on-Read Ring Interrupt Aggregator

This block gathers per-hop completion events from a multi-hop DMA engine and turns them into one interrupt line. Three kinds of event are tracked for every hop: transmit completion, receive completion and receive overflow. Each event sets a sticky status bit. The bits are packed into a run of 32-bit status words that software fetches through a simple register read port. Reading a status word returns its contents and clears it in the same access.

Software controls which hops may interrupt through an enable word that it writes and reads back. The interrupt output is a one-cycle pulse. Once it has fired, the block is disarmed. It arms again only after software has read every status word in the set, including words that hold only disabled or idle bits. At that point any enabled bits still pending fire a fresh pulse. A read-only register reports the number of hops that the block was built for.

Top module: `ring_irq_agg`

## Requirements
- R1: The status vector is the concatenation {overflow, receive, transmit}, so the transmit event of hop h sets bit h, the receive event sets bit HOPS+h and the overflow event sets bit 2*HOPS+h. Status word k holds vector bits 32k+31..32k and is read at address STAT_BASE+k. There are (31+3*HOPS)/32 status words (two for HOPS=12).
- R2: Bits of the last status word at positions 3*HOPS and above always read as zero.
- R3: A read with rd_en high returns its word on rd_data one cycle later and clears that status word. An event that arrives in the same cycle as the read of its word is not in the returned value, is kept, and appears in the next read.
- R4: The enable word(s) start at MASK_BASE, and there are (31+2*HOPS)/32 of them. Bits HOPS-1..0 enable receive, and bits 2*HOPS-1..HOPS enable transmit. A write with wr_en high replaces the whole word. The word reads back as written, and bits at 2*HOPS and above read as zero.
- R5: When armed, an enabled set status bit makes irq high for exactly one cycle, two clock edges after the event is presented. An overflow bit is enabled by the receive enable of the same hop.
- R6: A status bit whose enable is clear still latches and reads back, but raises no interrupt.
- R7: After irq fires, no further irq occurs until every status word has been read at least once, even when some of those words hold only disabled bits. Events arriving in that time are latched.
- R8: The read that completes the set re-arms the block. If enabled bits are still set after that read, irq pulses in the cycle after the read data appears. Otherwise irq stays low until a new enabled event arrives.
- R9: Address HOPS_ADDR reads the hop count in bits 10..0, with zero above.
- R10: After reset, all status and enable bits are zero, the block is armed and irq is low. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_evt | input | HOPS | Per-hop transmit completion pulses |
| rx_evt | input | HOPS | Per-hop receive completion pulses |
| ovf_evt | input | HOPS | Per-hop receive overflow pulses |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | AW | Register read word address |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write word address |
| wr_data | input | 32 | Register write data |
| irq | output | 1 | Interrupt pulse |

## Verification
The bench targets four corner cases.

- It places overflow events on hops whose bit falls in the second status word. A design that packed the fields per word instead of back to back would return them in the wrong word or bit.
- It reads a word in the very cycle an event for that word arrives. A design that cleared after merging would silently lose the event.
- It leaves the second word, which holds only disabled bits, unread after an interrupt. A design that re-armed on the enabled words alone would fire early.
- It lets an enabled bit arrive between the first and last read. A design that re-armed without re-evaluating pending bits would never raise the follow-up pulse.

// File: rtl/ria_pkg.sv
package ria_pkg;

    function automatic int words_for(input int nbits);
        return (31 + nbits) / 32;
    endfunction

    function automatic int idx_width(input int nwords);
        return (nwords > 1) ? $clog2(nwords) : 1;
    endfunction

endpackage

// File: rtl/ria_status.sv
module ria_status #(
    parameter  int HOPS = 12,
    localparam int NST  = 3 * HOPS,
    localparam int NSW  = ria_pkg::words_for(NST),
    localparam int SIW  = ria_pkg::idx_width(NSW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HOPS-1:0]   tx_evt,
    input  logic [HOPS-1:0]   rx_evt,
    input  logic [HOPS-1:0]   ovf_evt,
    input  logic              clr_en,
    input  logic [SIW-1:0]    clr_idx,
    output logic [NSW*32-1:0] stat_o
);

    typedef struct packed {
        logic [NST-1:0] bits;
    } st_t;

    st_t s_d, s_q;
    logic [NSW*32-1:0] wipe;

    always_comb begin
        stat_o = '0;
        stat_o[NST-1:0] = s_q.bits;
        wipe = '0;
        for (int w = 0; w < NSW; w++) begin
            if (clr_en && clr_idx == SIW'(w)) begin
                wipe[w*32 +: 32] = '1;
            end
        end
        s_d.bits = (s_q.bits & ~wipe[NST-1:0]) | {ovf_evt, rx_evt, tx_evt};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/ria_mask.sv
module ria_mask #(
    parameter  int HOPS = 12,
    localparam int NMK  = 2 * HOPS,
    localparam int NMW  = ria_pkg::words_for(NMK),
    localparam int MIW  = ria_pkg::idx_width(NMW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MIW-1:0]    wr_idx,
    input  logic [31:0]       wr_data,
    output logic [NMW*32-1:0] mask_o
);

    typedef struct packed {
        logic [NMK-1:0] bits;
    } mk_t;

    mk_t m_d, m_q;
    logic [NMW*32-1:0] wide;

    always_comb begin
        mask_o = '0;
        mask_o[NMK-1:0] = m_q.bits;
        wide = mask_o;
        for (int w = 0; w < NMW; w++) begin
            if (wr_en && wr_idx == MIW'(w)) begin
                wide[w*32 +: 32] = wr_data;
            end
        end
        m_d.bits = wide[NMK-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

endmodule

// File: rtl/ria_arm.sv
module ria_arm #(
    parameter  int NSW = 2,
    localparam int SIW = ria_pkg::idx_width(NSW)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pend,
    input  logic           rd_stat,
    input  logic [SIW-1:0] rd_idx,
    output logic           irq_o
);

    typedef struct packed {
        logic           armed;
        logic [NSW-1:0] seen;
        logic           irq;
    } arm_t;

    arm_t a_d, a_q;
    logic [NSW-1:0] hit;
    logic [NSW-1:0] all_seen;

    always_comb begin
        hit = '0;
        for (int w = 0; w < NSW; w++) begin
            if (rd_idx == SIW'(w)) begin
                hit[w] = 1'b1;
            end
        end
        all_seen = a_q.seen | hit;
        a_d = a_q;
        a_d.irq = a_q.armed & pend;
        if (a_q.armed && pend) begin
            a_d.armed = 1'b0;
        end else if (!a_q.armed && rd_stat) begin
            if (&all_seen) begin
                a_d.armed = 1'b1;
                a_d.seen  = '0;
            end else begin
                a_d.seen  = all_seen;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q.armed <= 1'b1;
            a_q.seen  <= '0;
            a_q.irq   <= 1'b0;
        end else begin
            a_q <= a_d;
        end
    end

    assign irq_o = a_q.irq;

endmodule

// File: rtl/ring_irq_agg.sv
module ring_irq_agg #(
    parameter int HOPS      = 12,
    parameter int AW        = 6,
    parameter int STAT_BASE = 0,
    parameter int MASK_BASE = 8,
    parameter int HOPS_ADDR = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [HOPS-1:0] tx_evt,
    input  logic [HOPS-1:0] rx_evt,
    input  logic [HOPS-1:0] ovf_evt,
    input  logic            rd_en,
    input  logic [AW-1:0]   rd_addr,
    output logic [31:0]     rd_data,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [31:0]     wr_data,
    output logic            irq
);

    localparam int NST = 3 * HOPS;
    localparam int NSW = ria_pkg::words_for(NST);
    localparam int NMW = ria_pkg::words_for(2 * HOPS);
    localparam int SIW = ria_pkg::idx_width(NSW);
    localparam int MIW = ria_pkg::idx_width(NMW);
    localparam logic [AW-1:0] STAT_LO = AW'(STAT_BASE);
    localparam logic [AW-1:0] MASK_LO = AW'(MASK_BASE);
    localparam logic [AW-1:0] HOPS_LO = AW'(HOPS_ADDR);

    typedef struct packed {
        logic [31:0] rdata;
    } rd_t;

    rd_t r_d, r_q;

    logic [NSW*32-1:0] stat_w;
    logic [NMW*32-1:0] mask_w;
    logic [NST-1:0]    en_vec;
    logic [AW-1:0]     soff, moff, woff;
    logic              stat_hit, mask_hit, wr_hit;
    logic              pend_any;

    assign soff     = rd_addr - STAT_LO;
    assign moff     = rd_addr - MASK_LO;
    assign woff     = wr_addr - MASK_LO;
    assign stat_hit = soff < AW'(NSW);
    assign mask_hit = moff < AW'(NMW);
    assign wr_hit   = wr_en && (woff < AW'(NMW));

    ria_status #(.HOPS(HOPS)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_evt  (tx_evt),
        .rx_evt  (rx_evt),
        .ovf_evt (ovf_evt),
        .clr_en  (rd_en && stat_hit),
        .clr_idx (soff[SIW-1:0]),
        .stat_o  (stat_w)
    );

    ria_mask #(.HOPS(HOPS)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_hit),
        .wr_idx  (woff[MIW-1:0]),
        .wr_data (wr_data),
        .mask_o  (mask_w)
    );

    // Enable fan-out: transmit bits use the upper half, receive and overflow the lower half.
    for (genvar h = 0; h < HOPS; h++) begin : g_en
        assign en_vec[h]          = mask_w[HOPS + h];
        assign en_vec[HOPS + h]   = mask_w[h];
        assign en_vec[2*HOPS + h] = mask_w[h];
    end

    assign pend_any = |(stat_w[NST-1:0] & en_vec);

    ria_arm #(.NSW(NSW)) u_arm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend    (pend_any),
        .rd_stat (rd_en && stat_hit),
        .rd_idx  (soff[SIW-1:0]),
        .irq_o   (irq)
    );

    always_comb begin
        r_d = r_q;
        if (rd_en) begin
            r_d.rdata = '0;
            if (stat_hit) begin
                for (int w = 0; w < NSW; w++) begin
                    if (soff == AW'(w)) r_d.rdata = stat_w[w*32 +: 32];
                end
            end else if (mask_hit) begin
                for (int w = 0; w < NMW; w++) begin
                    if (moff == AW'(w)) r_d.rdata = mask_w[w*32 +: 32];
                end
            end else if (rd_addr == HOPS_LO) begin
                r_d.rdata[10:0] = 11'(HOPS);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_data = r_q.rdata;

endmodule

// File: rtl/ria_chk.sv
module ria_chk #(
    parameter int HOPS      = 12,
    parameter int AW        = 6,
    parameter int STAT_BASE = 0,
    parameter int MASK_BASE = 8,
    parameter int HOPS_ADDR = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic [HOPS-1:0] tx_evt,
    input logic [HOPS-1:0] rx_evt,
    input logic [HOPS-1:0] ovf_evt,
    input logic            rd_en,
    input logic [AW-1:0]   rd_addr,
    input logic [31:0]     rd_data,
    input logic            irq,
    input logic            pend_any
);

    localparam int NST = 3 * HOPS;
    localparam int NSW = ria_pkg::words_for(NST);
    localparam int NMW = ria_pkg::words_for(2 * HOPS);

    logic            stat_addr;
    logic [AW-1:0]   s_off;
    logic            no_evt;

    assign s_off     = rd_addr - AW'(STAT_BASE);
    assign stat_addr = s_off < AW'(NSW);
    assign no_evt    = ~|{ovf_evt, rx_evt, tx_evt};

    // R5
    irq_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R5
    irq_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(pend_any));

    // R9
    hop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == AW'(HOPS_ADDR)) |=> rd_data == 32'(HOPS % 2048));

    // R3
    reread_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_en) && rd_en && stat_addr && rd_addr == $past(rd_addr) && $past(no_evt))
        |=> rd_data == 32'd0);

    if (NST % 32 != 0) begin : g_spad
        // R2
        stat_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && rd_addr == AW'(STAT_BASE + NSW - 1)) |=> rd_data[31:NST%32] == '0);
    end

    if ((2 * HOPS) % 32 != 0) begin : g_mpad
        // R4
        mask_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && rd_addr == AW'(MASK_BASE + NMW - 1)) |=> rd_data[31:(2*HOPS)%32] == '0);
    end

endmodule

bind ring_irq_agg ria_chk #(
    .HOPS(HOPS), .AW(AW), .STAT_BASE(STAT_BASE), .MASK_BASE(MASK_BASE), .HOPS_ADDR(HOPS_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_evt   (tx_evt),
    .rx_evt   (rx_evt),
    .ovf_evt  (ovf_evt),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .irq      (irq),
    .pend_any (pend_any)
);

// File: tb/ring_irq_agg_tb.sv
`timescale 1ns/1ps
module ring_irq_agg_tb;

    localparam int HOPS = 12;
    localparam int AW   = 6;
    localparam int SB   = 0;
    localparam int MB   = 8;
    localparam int HA   = 12;
    localparam int NST  = 3 * HOPS;
    localparam int NSW  = 2;
    localparam int NMW  = 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [HOPS-1:0] tx_evt = '0, rx_evt = '0, ovf_evt = '0;
    logic            rd_en = 1'b0, wr_en = 1'b0;
    logic [AW-1:0]   rd_addr = '0, wr_addr = '0;
    logic [31:0]     wr_data = '0;
    logic [31:0]     rd_data;
    logic            irq;

    int n_chk = 0;
    int n_err = 0;
    int irq_cnt = 0;

    always #4 clk = ~clk;

    ring_irq_agg #(.HOPS(HOPS), .AW(AW), .STAT_BASE(SB), .MASK_BASE(MB), .HOPS_ADDR(HA)) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_evt(tx_evt), .rx_evt(rx_evt), .ovf_evt(ovf_evt),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference, updated on each rising edge
    bit [NST-1:0]    m_stat;
    bit [2*HOPS-1:0] m_mask;
    bit [NSW-1:0]    m_seen;
    bit              m_armed, m_irq, m_rdv;
    bit [31:0]       m_rd;

    always @(posedge clk) begin : model
        bit pend, sread;
        int a, w;
        bit [NST-1:0] nst, en;
        if (!rst_n) begin
            m_stat = '0; m_mask = '0; m_seen = '0;
            m_armed = 1; m_irq = 0; m_rdv = 0; m_rd = 0;
        end else begin
            en = {m_mask[HOPS-1:0], m_mask[HOPS-1:0], m_mask[2*HOPS-1:HOPS]};
            pend = |(m_stat & en);
            nst = m_stat;
            sread = 0;
            w = 0;
            m_rdv = rd_en;
            if (rd_en) begin
                a = int'(rd_addr);
                m_rd = 0;
                if (a >= SB && a < SB + NSW) begin
                    w = a - SB;
                    sread = 1;
                    for (int b = 0; b < 32; b++) begin
                        if (32 * w + b < NST) begin
                            m_rd[b] = m_stat[32 * w + b];
                            nst[32 * w + b] = 0;
                        end
                    end
                end else if (a >= MB && a < MB + NMW) begin
                    for (int b = 0; b < 32; b++)
                        if (32 * (a - MB) + b < 2 * HOPS) m_rd[b] = m_mask[32 * (a - MB) + b];
                end else if (a == HA) begin
                    m_rd = HOPS;
                end
            end
            nst = nst | {ovf_evt, rx_evt, tx_evt};
            if (wr_en && int'(wr_addr) >= MB && int'(wr_addr) < MB + NMW) begin
                for (int b = 0; b < 32; b++)
                    if (32 * (int'(wr_addr) - MB) + b < 2 * HOPS)
                        m_mask[32 * (int'(wr_addr) - MB) + b] = wr_data[b];
            end
            if (m_armed && pend) begin
                m_irq = 1;
                m_armed = 0;
            end else begin
                m_irq = 0;
                if (!m_armed && sread) begin
                    m_seen[w] = 1;
                    if (&m_seen) begin
                        m_armed = 1;
                        m_seen = '0;
                    end
                end
            end
            m_stat = nst;
        end
    end

    // Clock-by-clock comparison against the reference (R7, R8 on irq; R3 on read data)
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq) irq_cnt++;
            chk(irq == m_irq, "R7/R8 irq vs model", 32'(irq), 32'(m_irq));
            if (m_rdv) chk(rd_data == m_rd, "R3 rd_data vs model", rd_data, m_rd);
        end
    end

    task automatic do_read(input int addr, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = AW'(addr);
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic do_write(input int addr, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(addr); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [HOPS-1:0] t, input logic [HOPS-1:0] r, input logic [HOPS-1:0] o);
        @(negedge clk);
        tx_evt = t; rx_evt = r; ovf_evt = o;
        @(negedge clk);
        tx_evt = '0; rx_evt = '0; ovf_evt = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (400) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        int c0;
        idle(3);
        rst_n = 1'b1;

        // R10 reset state
        chk(irq == 1'b0, "R10 irq low after reset", 32'(irq), 0);
        do_read(SB, d);     chk(d == 0, "R10 status word0 after reset", d, 0);
        do_read(SB + 1, d); chk(d == 0, "R10 status word1 after reset", d, 0);
        do_read(MB, d);     chk(d == 0, "R10 enable word after reset", d, 0);
        do_read(20, d);     chk(d == 0, "R10 unmapped address", d, 0);

        // R9 hop count register
        do_read(HA, d);     chk(d == 32'd12, "R9 hop count", d, 12);

        // R6 disabled event latches but stays silent
        c0 = irq_cnt;
        pulse(12'h008, '0, '0);
        idle(4);
        chk(irq_cnt == c0, "R6 no irq with enables clear", irq_cnt, c0);
        do_read(SB, d);     chk(d == 32'h8, "R6 tx hop3 latched at bit 3", d, 32'h8);
        do_read(SB, d);     chk(d == 0, "R3 word cleared by read", d, 0);

        // R4 enable word write and read-back
        do_write(MB, 32'hFFFF_FFFF);
        do_read(MB, d);     chk(d == 32'h00FF_FFFF, "R4 enable upper bits zero", d, 32'h00FF_FFFF);
        do_write(MB, 32'h0000_0FFF);
        do_read(MB, d);     chk(d == 32'h0000_0FFF, "R4 receive enables only", d, 32'hFFF);

        // R5 overflow pulse timing (overflow gated by receive enable), R1 boundary
        pulse('0, '0, 12'h200);
        chk(irq == 1'b0, "R5 irq not yet on first edge", 32'(irq), 0);
        @(negedge clk);
        chk(irq == 1'b1, "R5 irq on second edge", 32'(irq), 1);
        @(negedge clk);
        chk(irq == 1'b0, "R5 irq lasts one cycle", 32'(irq), 0);

        // R7 no re-fire while words remain unread
        c0 = irq_cnt;
        pulse('0, 12'h010, '0);
        idle(4);
        chk(irq_cnt == c0, "R7 disarmed, no irq before reads", irq_cnt, c0);
        do_read(SB + 1, d); chk(d == 32'h2, "R1 overflow hop9 in word1 bit1", d, 32'h2);
        idle(3);
        chk(irq_cnt == c0, "R7 still disarmed with word0 unread", irq_cnt, c0);
        do_read(SB, d);     chk(d == 32'h0001_0000, "R1 rx hop4 at bit16", d, 32'h10000);
        idle(3);
        chk(irq_cnt == c0, "R8 re-armed with nothing pending", irq_cnt, c0);

        // R8 pending bit at re-arm fires right after the completing read
        pulse('0, 12'h002, '0);
        idle(2);
        chk(irq_cnt == c0 + 1, "R5 rx hop1 raises irq", irq_cnt, c0 + 1);
        do_read(SB, d);     chk(d == 32'h0000_2000, "R1 rx hop1 at bit13", d, 32'h2000);
        pulse('0, 12'h020, '0);
        do_read(SB + 1, d); chk(d == 0, "R3 word1 empty", d, 0);
        chk(irq == 1'b0, "R8 no irq in read-data cycle", 32'(irq), 0);
        @(negedge clk);
        chk(irq == 1'b1, "R8 irq after completing read", 32'(irq), 1);
        do_read(SB, d);     chk(d == 32'h0002_0000, "R1 rx hop5 at bit17", d, 32'h20000);
        do_read(SB + 1, d);

        // R3 event in the same cycle as the read of its word
        do_write(MB, 32'h0);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = AW'(SB); tx_evt = 12'h004;
        @(negedge clk);
        rd_en = 1'b0; tx_evt = '0;
        chk(rd_data == 0, "R3 same-cycle event not in read", rd_data, 0);
        do_read(SB, d);     chk(d == 32'h4, "R3 same-cycle event kept", d, 32'h4);

        // R1 / R2 overflow field across the word boundary
        pulse('0, '0, 12'hFFF);
        do_read(SB + 1, d); chk(d == 32'hF, "R2 word1 upper bits zero", d, 32'hF);
        do_read(SB, d);     chk(d == 32'hFF00_0000, "R1 overflow hops0-7 top of word0", d, 32'hFF000000);

        // R7 word holding only disabled bits still gates re-arm
        do_write(MB, 32'h00FF_F000);
        c0 = irq_cnt;
        pulse(12'h800, '0, '0);
        idle(2);
        chk(irq_cnt == c0 + 1, "R5 tx hop11 raises irq", irq_cnt, c0 + 1);
        pulse('0, '0, 12'h400);
        do_read(SB, d);     chk(d == 32'h800, "R1 tx hop11 at bit11", d, 32'h800);
        idle(3);
        chk(irq_cnt == c0 + 1, "R7 disabled-only word unread blocks re-arm", irq_cnt, c0 + 1);
        do_read(SB + 1, d); chk(d == 32'h4, "R6 disabled overflow latched", d, 32'h4);
        idle(3);
        chk(irq_cnt == c0 + 1, "R6 disabled pending bit no irq", irq_cnt, c0 + 1);
        pulse(12'h001, '0, '0);
        idle(2);
        chk(irq_cnt == c0 + 2, "R8 re-armed block fires on new event", irq_cnt, c0 + 2);
        idle(2);

        summary();
        $finish;
    end

endmodule